// File: doc/BRIEF.md
# Unaligned Access Splitter with Alignment Fault Check

This block sits between a load/store pipeline and a 64-bit data bus. It takes byte, halfword, word and doubleword requests at any byte address and checks each one against two mode inputs: one that allows unaligned accesses and one that enforces strict alignment. A request that fails the check gets a fault response and starts no bus cycle.

A legal request whose bytes all lie inside one bus word uses one bus cycle. A legal request that crosses into the next bus word uses two bus cycles. For loads, the block merges and shifts the two words. For stores, it drives lane byte enables for each cycle. The bus address is the byte address with its three low bits removed. Those low bits choose the starting byte lane.

Requests carry a kind field. Grouped transfers (multiple, paired, atomic) must be word aligned, and 16-byte operand types must be 16-byte aligned. Both rules apply whatever the mode inputs say. Each accepted request returns exactly one response.

Top module: `unaligned_splitter`

## Requirements
- R1: After a synchronous reset, req_ready is 1 and bus_valid and rsp_valid are 0.
- R2: For a plain request (req_kind 0 or 3), the size field gives the access width: req_size 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A request is misaligned when the address is not a multiple of its byte count. A misaligned plain request faults when mode_strict is 1 or mode_unaligned_en is 0. When both mode inputs are 1, strict wins and the request faults.
- R3: A request with req_kind 1 (grouped) faults when the address is not a multiple of 4, whatever the mode inputs are.
- R4: A request with req_kind 2 (16-byte operand) faults when the address is not a multiple of 16, whatever the mode inputs are.
- R5: A plain byte request never faults and always uses exactly one bus cycle.
- R6: A faulting request produces rsp_valid with rsp_fault=1 one cycle after acceptance. It starts no bus cycle and changes no memory byte.
- R7: A legal request whose byte span (address mod 8 plus byte count) is at most 8 uses one bus cycle, with bus_addr equal to the byte address divided by 8.
- R8: A legal request whose byte span exceeds 8 uses two bus cycles. The second cycle is at bus_addr plus 1.
- R9: The load data is little-endian, with the byte at the requested address in bits 7:0. It is zero-extended to 64 bits, or sign-extended when req_signed is 1.
- R10: A store writes only the bytes of the access. Byte lane i of bus_be and bus_wdata carries address (8*bus_addr + i). All other memory bytes are left unchanged.
- R11: req_ready is 1 only while no access is in progress. Each accepted request produces exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_unaligned_en | input | 1 | Allow unaligned plain accesses |
| mode_strict | input | 1 | Fault every misaligned plain access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend load data |
| req_size | input | 2 | Access width code (0..3 = 1,2,4,8 bytes) |
| req_kind | input | 2 | 0 plain, 1 grouped, 2 16-byte operand, 3 plain |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data, least significant byte first |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | Bus cycle is a write |
| bus_addr | output | AW-3 | Bus word address |
| bus_be | output | DW/8 | Byte lane enables |
| bus_wdata | output | DW | Write data by lane |
| bus_ack | input | 1 | Bus completes the current cycle |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is an alignment fault |
| rsp_data | output | DW | Load result (zero for stores and faults) |

## Verification
Loads and stores are tried at offsets that stay inside a bus word, that end exactly on its last lane, and that cross into the next word. This separates the one-cycle path from the two-cycle path and exposes off-by-one errors in the span test. The same misaligned addresses are sent under each combination of the mode inputs and under the grouped and 16-byte kinds. This shows which of the fault rules fired and that strict checking overrides the enable. Signed loads read bytes with the top bit set, so zero extension and sign extension give different results. A store followed by an overlapping unaligned load, together with a compare of the whole memory, shows whether any lane outside the access was written. A reset during a split access checks the return to the idle state.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;
  typedef enum logic [1:0] {K_PLAIN = 2'd0, K_GROUP = 2'd1, K_QUAD = 2'd2, K_SPARE = 2'd3} acc_kind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FIRST = 2'd1, ST_SECOND = 2'd2} split_st_e;
endpackage

// File: rtl/usplit_align_chk.sv
module usplit_align_chk
  import usplit_pkg::*;
(
  input  logic [3:0] addr_lo,
  input  logic [1:0] size,
  input  logic [1:0] kind,
  input  logic       ua_en,
  input  logic       strict,
  output logic       fault
);
  logic misal;
  logic kind_bad;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_B:    misal = 1'b0;
      SZ_H:    misal = addr_lo[0];
      SZ_W:    misal = |addr_lo[1:0];
      default: misal = |addr_lo[2:0];
    endcase
    unique case (acc_kind_e'(kind))
      K_GROUP: kind_bad = |addr_lo[1:0];
      K_QUAD:  kind_bad = |addr_lo[3:0];
      default: kind_bad = 1'b0;
    endcase
    fault = (misal && (strict || !ua_en)) || kind_bad;
  end
endmodule

// File: rtl/usplit_lane_map.sv
module usplit_lane_map #(
  parameter int DW = 64
) (
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [1:0]              size,
  input  logic [DW-1:0]           wdata,
  output logic [DW/8-1:0]         be_lo,
  output logic [DW/8-1:0]         be_hi,
  output logic [DW-1:0]           wd_lo,
  output logic [DW-1:0]           wd_hi,
  output logic                    split
);
  localparam int LANES = DW / 8;

  logic [3:0]         nbytes;
  logic [2*LANES-1:0] base;
  logic [2*LANES-1:0] span;
  logic [DW-1:0]      wmasked;
  logic [2*DW-1:0]    wide;

  always_comb begin
    nbytes = 4'd1 << size;
    base   = '0;
    for (int i = 0; i < LANES; i++) begin
      base[i] = (i < int'(nbytes));
    end
    for (int b = 0; b < LANES; b++) begin
      wmasked[8*b +: 8] = base[b] ? wdata[8*b +: 8] : 8'h00;
    end
    span  = base << off;
    wide  = {{DW{1'b0}}, wmasked} << {off, 3'b000};
    be_lo = span[LANES-1:0];
    be_hi = span[2*LANES-1:LANES];
    wd_lo = wide[DW-1:0];
    wd_hi = wide[2*DW-1:DW];
    split = |be_hi;
  end
endmodule

// File: rtl/usplit_load_merge.sv
module usplit_load_merge #(
  parameter int DW = 64
) (
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [1:0]              size,
  input  logic                    sgn,
  input  logic [DW-1:0]           lo_word,
  input  logic [DW-1:0]           hi_word,
  output logic [DW-1:0]           data
);
  localparam int LANES = DW / 8;

  logic [3:0]      nbytes;
  logic [2*DW-1:0] cat;
  logic            top_bit;

  always_comb begin
    nbytes  = 4'd1 << size;
    cat     = {hi_word, lo_word} >> {off, 3'b000};
    top_bit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (i == int'(nbytes) - 1) top_bit = cat[8*i+7];
    end
    for (int i = 0; i < LANES; i++) begin
      data[8*i +: 8] = (i < int'(nbytes)) ? cat[8*i +: 8] : {8{sgn & top_bit}};
    end
  end
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import usplit_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             mode_unaligned_en,
  input  logic                             mode_strict,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_write,
  input  logic                             req_signed,
  input  logic [1:0]                       req_size,
  input  logic [1:0]                       req_kind,
  input  logic [AW-1:0]                    req_addr,
  input  logic [DW-1:0]                    req_wdata,
  output logic                             bus_valid,
  output logic                             bus_write,
  output logic [AW-$clog2(DW/8)-1:0]       bus_addr,
  output logic [DW/8-1:0]                  bus_be,
  output logic [DW-1:0]                    bus_wdata,
  input  logic                             bus_ack,
  input  logic [DW-1:0]                    bus_rdata,
  output logic                             rsp_valid,
  output logic                             rsp_fault,
  output logic [DW-1:0]                    rsp_data
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  split_st_e         state;
  logic              chk_fault;
  logic [LANES-1:0]  be_lo, be_hi, r_be_hi;
  logic [DW-1:0]     wd_lo, wd_hi, r_wd_hi;
  logic              split, r_split;
  logic [OFFW-1:0]   r_off;
  logic [1:0]        r_size;
  logic              r_signed;
  logic [DW-1:0]     r_lo;
  logic [DW-1:0]     ld_data;
  logic [DW-1:0]     merge_lo;

  usplit_align_chk u_chk (
    .addr_lo (req_addr[3:0]),
    .size    (req_size),
    .kind    (req_kind),
    .ua_en   (mode_unaligned_en),
    .strict  (mode_strict),
    .fault   (chk_fault)
  );

  usplit_lane_map #(.DW(DW)) u_lanes (
    .off   (req_addr[OFFW-1:0]),
    .size  (req_size),
    .wdata (req_wdata),
    .be_lo (be_lo),
    .be_hi (be_hi),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi),
    .split (split)
  );

  assign merge_lo = (state == ST_SECOND) ? r_lo : bus_rdata;

  usplit_load_merge #(.DW(DW)) u_merge (
    .off     (r_off),
    .size    (r_size),
    .sgn     (r_signed),
    .lo_word (merge_lo),
    .hi_word (bus_rdata),
    .data    (ld_data)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data  <= '0;
      r_be_hi   <= '0;
      r_wd_hi   <= '0;
      r_split   <= 1'b0;
      r_off     <= '0;
      r_size    <= '0;
      r_signed  <= 1'b0;
      r_lo      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (chk_fault) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_data  <= '0;
            end else begin
              bus_valid <= 1'b1;
              bus_write <= req_write;
              bus_addr  <= req_addr[AW-1:OFFW];
              bus_be    <= be_lo;
              bus_wdata <= wd_lo;
              r_be_hi   <= be_hi;
              r_wd_hi   <= wd_hi;
              r_split   <= split;
              r_off     <= req_addr[OFFW-1:0];
              r_size    <= req_size;
              r_signed  <= req_signed;
              state     <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (bus_ack) begin
            if (r_split) begin
              r_lo      <= bus_rdata;
              bus_addr  <= bus_addr + 1'b1;
              bus_be    <= r_be_hi;
              bus_wdata <= r_wd_hi;
              state     <= ST_SECOND;
            end else begin
              bus_valid <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_data  <= bus_write ? '0 : ld_data;
              state     <= ST_IDLE;
            end
          end
        end
        default: begin
          if (bus_ack) begin
            bus_valid <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_data  <= bus_write ? '0 : ld_data;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module unaligned_splitter_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [1:0]                 req_size,
  input logic                       chk_fault,
  input logic                       bus_valid,
  input logic                       bus_ack,
  input logic [AW-$clog2(DW/8)-1:0] bus_addr,
  input logic [DW/8-1:0]            bus_be,
  input logic                       rsp_valid,
  input logic                       rsp_fault
);
  localparam int BAW = AW - $clog2(DW/8);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !bus_valid && !rsp_valid));

  assert_fault_skips_bus_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && chk_fault) |=> (rsp_valid && rsp_fault && !bus_valid));

  assert_byte_never_faults_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size == 2'd0) |=> !(rsp_valid && rsp_fault));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !req_ready);

  assert_lanes_enabled_R10: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_be != '0));

  assert_second_word_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_valid && bus_ack) && bus_valid) |-> (bus_addr == BAW'($past(bus_addr) + 1'b1)));
endmodule

bind unaligned_splitter unaligned_splitter_chk #(.AW(AW), .DW(DW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .chk_fault (chk_fault),
  .bus_valid (bus_valid),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault)
);

// File: tb/tb_unaligned_splitter.sv
module tb_unaligned_splitter;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int MB = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_unaligned_en = 1'b0, mode_strict = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0] req_size = '0, req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, bus_valid, bus_write, rsp_valid, rsp_fault;
  logic [AW-4:0] bus_addr;
  logic [7:0] bus_be;
  logic [DW-1:0] bus_wdata, bus_rdata, rsp_data;
  logic bus_ack;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] mem [MB];
  logic [7:0] ref_mem [MB];

  always #4 clk = ~clk;

  unaligned_splitter #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .mode_unaligned_en(mode_unaligned_en), .mode_strict(mode_strict),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_signed(req_signed),
    .req_size(req_size), .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  assign bus_ack = 1'b1;
  always_comb begin
    for (int l = 0; l < 8; l++) bus_rdata[8*l +: 8] = mem[{bus_addr[3:0], 3'(l)}];
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MB; i++) mem[i] <= pat(i);
    end else if (bus_valid && bus_write) begin
      for (int l = 0; l < 8; l++)
        if (bus_be[l]) mem[{bus_addr[3:0], 3'(l)}] <= bus_wdata[8*l +: 8];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [1:0]  kd;
    logic        sg;
    logic        ua;
    logic        st;
    logic [6:0]  addr;
    logic [63:0] wd;
    logic        ef;
    logic [1:0]  ec;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 7'd8,  64'h0, 1'b0, 2'd1},
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'd13, 64'h0, 1'b0, 2'd1},
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 7'd7,  64'h0, 1'b0, 2'd2},
    '{1'b0, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 7'd19, 64'h0, 1'b0, 2'd2},
    '{1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 7'd6,  64'h0, 1'b0, 2'd2},
    '{1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 7'd2,  64'h0, 1'b0, 2'd1},
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 7'd5,  64'h0, 1'b1, 2'd0},
    '{1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 7'd10, 64'h0, 1'b1, 2'd0},
    '{1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 7'd4,  64'h0, 1'b1, 2'd0},
    '{1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 7'd30, 64'hA1B2C3D4, 1'b0, 2'd2},
    '{1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 7'd41, 64'hBEEF, 1'b0, 2'd1},
    '{1'b1, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 7'd50, 64'h1122334455667788, 1'b0, 2'd2},
    '{1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 7'd6,  64'h0, 1'b1, 2'd0},
    '{1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 7'd12, 64'h0, 1'b0, 2'd1},
    '{1'b0, 2'd3, 2'd2, 1'b0, 1'b1, 1'b0, 7'd24, 64'h0, 1'b1, 2'd0},
    '{1'b0, 2'd3, 2'd2, 1'b0, 1'b1, 1'b0, 7'd32, 64'h0, 1'b0, 2'd1},
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'd63, 64'h0, 1'b0, 2'd1},
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd71, 64'h5A, 1'b0, 2'd1},
    '{1'b0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 7'd30, 64'h0, 1'b0, 2'd2},
    '{1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 7'd14, 64'h0, 1'b0, 2'd1},
    '{1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 7'd33, 64'hFFFFFFFF, 1'b1, 2'd0},
    '{1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 7'd16, 64'h0, 1'b0, 2'd1}
  };

  task automatic run_vec(input vec_t v, input int idx);
    int n = 1 << v.sz;
    int off = int'(v.addr) % 8;
    logic mis, rf;
    int rcyc, cnt;
    logic [AW-4:0] a1, a2;
    logic [63:0] expd;
    string tag;
    mis = (v.sz == 2'd1 && v.addr[0]) || (v.sz == 2'd2 && v.addr[1:0] != 0) ||
          (v.sz == 2'd3 && v.addr[2:0] != 0);
    rf  = (mis && (v.st || !v.ua)) || (v.kd == 2'd1 && v.addr[1:0] != 0) ||
          (v.kd == 2'd2 && v.addr[3:0] != 0);
    rcyc = rf ? 0 : ((off + n > 8) ? 2 : 1);
    if (v.kd == 2'd1) tag = "R3";
    else if (v.kd == 2'd2) tag = "R4";
    else if (v.sz == 2'd0) tag = "R5";
    else tag = "R2";
    chk(rf == v.ef && rcyc == int'(v.ec), $sformatf("%s table row %0d", tag, idx), {63'd0, v.ef}, {63'd0, rf});

    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready while idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_write = v.we; req_signed = v.sg; req_size = v.sz; req_kind = v.kd;
    req_addr = AW'(v.addr); req_wdata = v.wd;
    mode_unaligned_en = v.ua; mode_strict = v.st;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0; a1 = '0; a2 = '0;
    for (int k = 0; k < 20; k++) begin
      if (bus_valid) begin
        if (cnt == 0) a1 = bus_addr; else a2 = bus_addr;
        cnt++;
        chk(req_ready == 1'b0, "R11 ready low while busy", {63'd0, req_ready}, 64'd0);
      end
      if (rsp_valid) break;
      @(negedge clk);
    end
    chk(rsp_valid == 1'b1, "R11 response returned", {63'd0, rsp_valid}, 64'd1);
    chk(rsp_fault == rf, $sformatf("%s fault flag row %0d", tag, idx), {63'd0, rsp_fault}, {63'd0, rf});
    chk(cnt == rcyc, $sformatf("R6 R7 R8 bus cycles row %0d", idx), 64'(cnt), 64'(rcyc));
    if (!rf) begin
      chk(a1 == AW'(v.addr) >> 3, "R7 first bus address", 64'(a1), 64'(AW'(v.addr) >> 3));
      if (rcyc == 2) chk(a2 == a1 + 1'b1, "R8 second bus address", 64'(a2), 64'(a1 + 1'b1));
      if (!v.we) begin
        expd = '0;
        for (int b = 0; b < n; b++) expd[8*b +: 8] = ref_mem[int'(v.addr) + b];
        if (v.sg && n < 8 && expd[8*n-1]) for (int b = n; b < 8; b++) expd[8*b +: 8] = 8'hFF;
        chk(rsp_data == expd, $sformatf("R9 load data row %0d", idx), rsp_data, expd);
      end else begin
        for (int b = 0; b < n; b++) ref_mem[int'(v.addr) + b] = v.wd[8*b +: 8];
      end
    end
    begin
      int bad = 0;
      for (int i = 0; i < MB; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, rf ? "R6 memory untouched by fault" : "R10 memory after access", 64'(bad), 64'd0);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single response pulse", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < MB; i++) ref_mem[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && rsp_valid == 1'b0, "R1 reset state",
        {61'd0, req_ready, bus_valid, rsp_valid}, 64'b100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1: reset in the middle of a split load returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd3; req_kind = 2'd0;
    req_addr = 32'd5; mode_unaligned_en = 1'b1; mode_strict = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_valid == 1'b1, "R8 split started", {63'd0, bus_valid}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < MB; i++) ref_mem[i] = pat(i);
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && rsp_valid == 1'b0, "R1 reset mid split",
        {61'd0, req_ready, bus_valid, rsp_valid}, 64'b100);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 no response after reset", {63'd0, rsp_valid}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule